// File: doc/BRIEF.md
# Vector/Scalar Register Number Extender

This block turns a short register operand taken from a 32-bit instruction into a full register number for an enlarged register file. It also marks the operand as a scalar or as the first element of a vector. The operand arrives together with an extension tag carried in the instruction prefix. That tag is either 2 or 3 bits wide, depending on how many tag bits the instruction format has room for.

Two operand classes are handled. An integer or floating-point operand is a 5-bit field and yields a 7-bit number. A condition-register operand is either a 3-bit field selector, which yields a 7-bit field number, or a 5-bit bit selector, which yields a 9-bit bit number. For scalar operands the tag bits sit above the field. For vector operands the field sits above the tag bits, which gives vector starting points at a fixed stride.

An all-zero tag leaves the operand exactly as the 32-bit instruction encodes it. The result is captured in a register whenever the input valid bit is high, and is presented one cycle later with its own valid bit.

Top module: `svx_regext`

## Requirements
- R1: While rst_ni is low and after it is released, before any valid input, valid_o is 0, regnum_o is 0 and vec_o is 0.
- R2: valid_o equals the valid_i of the previous clock edge. regnum_o and vec_o hold their value across any edge where valid_i is 0, whatever the other inputs are.
- R3: With cr_i=0 and tag_i=000, regnum_o equals field_i zero-extended, and vec_o is 0, for either tag width.
- R4: Integer/FP class (cr_i=0) with a 3-bit tag (wide_i=1) and tag_i[2]=0: vec_o=0 and regnum_o = tag_i[1:0]*32 + field_i.
- R5: Integer/FP class with a 3-bit tag and tag_i[2]=1: vec_o=1 and regnum_o = field_i*4 + tag_i[1:0].
- R6: Integer/FP class with a 2-bit tag (wide_i=0, tag_i[2] ignored). Tag 00 gives scalar field_i. Tag 01 gives scalar 32+field_i. Tag 10 gives vector field_i*4. Tag 11 gives vector field_i*4+2. Scalars therefore stay below 64.
- R7: Condition-field class (cr_i=1, crbit_i=0) with a 3-bit tag. The operand is field_i[2:0], and field_i[4:3] are ignored. With tag_i[2]=0, the result is scalar tag_i[1:0]*8 + operand. With tag_i[2]=1, the result is vector operand*16 + tag_i[1]*8 + tag_i[0]*4.
- R8: Condition-field class with a 2-bit tag (tag_i[2] ignored). Tag 00 gives scalar operand. Tag 01 gives scalar 8+operand. Tag 10 gives vector operand*16. Tag 11 gives vector operand*16+8.
- R9: Condition-bit class (cr_i=1, crbit_i=1). field_i[4:2] is mapped as the operand of R7/R8, and regnum_o = that field number*4 + field_i[1:0]. vec_o is as in R7/R8.
- R10: In the integer/FP and condition-field classes, regnum_o[8:7] is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Capture the operand on this edge |
| cr_i | input | 1 | 1 = condition-register operand, 0 = integer/FP operand |
| crbit_i | input | 1 | With cr_i=1: 1 = 5-bit bit operand, 0 = 3-bit field operand |
| wide_i | input | 1 | 1 = 3-bit tag, 0 = 2-bit tag in tag_i[1:0] |
| field_i | input | 5 | Register field from the instruction |
| tag_i | input | 3 | Extension tag from the prefix |
| valid_o | output | 1 | Registered result is from a valid input |
| regnum_o | output | 9 | Extended register, field or bit number |
| vec_o | output | 1 | 1 = vector operand, 0 = scalar |

## Verification
On every cycle, the assertions check several properties. The valid pipeline and the holding of the result are checked, as is the identity mapping for an all-zero integer tag. They also check that vector integer numbers end in the tag's low bits, that scalars from a 2-bit tag stay below 64, and that condition-bit selectors pass through. Vector condition fields are checked for landing on a multiple of four. The full numeric mapping of every field and tag value in each class is shown only by the bench's exhaustive sweep. That sweep covers the distinct 2-bit condition tag meanings and the ignored tag and field bits.

// File: rtl/svx_pkg.sv
package svx_pkg;
  localparam int FIELD_W = 5;
  localparam int TAG_W   = 3;
  localparam int SEL_W   = 2;                 // low tag bits / cr bit select
  localparam int CRF_OPW = 3;                 // cr field operand width
  localparam int GPR_W   = FIELD_W + SEL_W;   // 7
  localparam int CRF_W   = CRF_OPW + 4;       // 7
  localparam int NUM_W   = CRF_W + SEL_W;     // 9

  typedef struct packed {
    logic             vec;
    logic [NUM_W-1:0] num;
  } ext_res_t;
endpackage

// File: rtl/svx_tag_norm.sv
module svx_tag_norm
  import svx_pkg::*;
(
  input  logic [TAG_W-1:0] tag_i,
  input  logic             wide_i,
  output logic [TAG_W-1:0] spec_o
);
  // narrow tag: scalar uses bit0 as low select, vector uses {bit0,0}
  always_comb begin
    if (wide_i)        spec_o = tag_i;
    else if (tag_i[1]) spec_o = {1'b1, tag_i[0], 1'b0};
    else               spec_o = {1'b0, 1'b0, tag_i[0]};
  end
endmodule

// File: rtl/svx_gpr_map.sv
module svx_gpr_map
  import svx_pkg::*;
(
  input  logic [FIELD_W-1:0] field_i,
  input  logic [TAG_W-1:0]   spec_i,
  output logic [GPR_W-1:0]   num_o
);
  always_comb begin
    if (spec_i[TAG_W-1]) num_o = {field_i, spec_i[SEL_W-1:0]};
    else                 num_o = {spec_i[SEL_W-1:0], field_i};
  end
endmodule

// File: rtl/svx_cr_map.sv
module svx_cr_map
  import svx_pkg::*;
(
  input  logic [CRF_OPW-1:0] op_i,
  input  logic [TAG_W-1:0]   spec_i,
  output logic [CRF_W-1:0]   num_o
);
  // vector: stride 16 with start offsets 0/4/8/12; scalar: CR0..CR31
  always_comb begin
    if (spec_i[TAG_W-1]) num_o = {op_i, spec_i[1], spec_i[0], 2'b00};
    else                 num_o = {2'b00, spec_i[1:0], op_i};
  end
endmodule

// File: rtl/svx_regext.sv
module svx_regext
  import svx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               cr_i,
  input  logic               crbit_i,
  input  logic               wide_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic [TAG_W-1:0]   tag_i,
  output logic               valid_o,
  output logic [NUM_W-1:0]   regnum_o,
  output logic               vec_o
);
  logic [TAG_W-1:0]   spec;
  logic [GPR_W-1:0]   gpr_num;
  logic [CRF_W-1:0]   crf_num;
  logic [CRF_OPW-1:0] cr_op;
  ext_res_t           res_d, res_q;
  logic               vld_q;

  svx_tag_norm u_norm (.tag_i(tag_i), .wide_i(wide_i), .spec_o(spec));

  svx_gpr_map u_gpr (.field_i(field_i), .spec_i(spec), .num_o(gpr_num));

  // bit operand: field number is the upper three bits
  assign cr_op = crbit_i ? field_i[FIELD_W-1:SEL_W] : field_i[CRF_OPW-1:0];

  svx_cr_map u_cr (.op_i(cr_op), .spec_i(spec), .num_o(crf_num));

  always_comb begin
    res_d.vec = spec[TAG_W-1];
    if (!cr_i)        res_d.num = NUM_W'(gpr_num);
    else if (crbit_i) res_d.num = {crf_num, field_i[SEL_W-1:0]};
    else              res_d.num = NUM_W'(crf_num);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign valid_o  = vld_q;
  assign regnum_o = res_q.num;
  assign vec_o    = res_q.vec;
endmodule

// File: rtl/svx_regext_chk.sv
module svx_regext_chk
  import svx_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               cr_i,
  input logic               crbit_i,
  input logic               wide_i,
  input logic [FIELD_W-1:0] field_i,
  input logic [TAG_W-1:0]   tag_i,
  input logic               valid_o,
  input logic [NUM_W-1:0]   regnum_o,
  input logic               vec_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> valid_o == $past(valid_i));

  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(valid_i)) |-> ($stable(regnum_o) && $stable(vec_o)));

  p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !past_ok |-> (!valid_o && regnum_o == '0 && !vec_o));

  p_zero_tag_identity_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i && !cr_i && tag_i == '0))
      |-> (regnum_o == NUM_W'($past(field_i)) && !vec_o));

  p_gpr_vec_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i && !cr_i && wide_i && tag_i[2]))
      |-> (vec_o && regnum_o[1:0] == $past(tag_i[1:0])));

  p_narrow_scalar_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i && !cr_i && !wide_i) && !vec_o) |-> regnum_o < 64);

  p_crbit_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i && cr_i && crbit_i))
      |-> regnum_o[1:0] == $past(field_i[1:0]));

  p_crf_vec_align_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i && cr_i && !crbit_i) && vec_o)
      |-> (regnum_o[1:0] == 2'b00));

  p_upper_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i && !(cr_i && crbit_i))) |-> regnum_o[8:7] == 2'b00);
endmodule

bind svx_regext svx_regext_chk u_chk (.*);

// File: tb/svx_regext_bench.sv
`timescale 1ns/1ps
module svx_regext_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0, cr_i = 1'b0, crbit_i = 1'b0, wide_i = 1'b0;
  logic [4:0] field_i = '0;
  logic [2:0] tag_i = '0;
  logic       valid_o, vec_o;
  logic [8:0] regnum_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk_i = ~clk_i;

  svx_regext u_svx_regext (.*);

  // behavioural model: returns vec*1000 + number
  function automatic int model(int cr, int crb, int wide, int tag, int fld);
    int t, op, fnum, vec, num;
    t = wide ? tag : (tag % 4);
    if (cr == 0) begin
      if (wide != 0) begin
        if (t >= 4) begin vec = 1; num = fld*4 + (t-4); end
        else        begin vec = 0; num = t*32 + fld; end
      end else begin
        case (t)
          0: begin vec = 0; num = fld; end
          1: begin vec = 0; num = 32 + fld; end
          2: begin vec = 1; num = fld*4; end
          default: begin vec = 1; num = fld*4 + 2; end
        endcase
      end
    end else begin
      op = (crb != 0) ? fld / 4 : fld % 8;
      if (wide != 0) begin
        if (t >= 4) begin vec = 1; fnum = op*16 + ((t/2)%2)*8 + (t%2)*4; end
        else        begin vec = 0; fnum = t*8 + op; end
      end else begin
        case (t)
          0: begin vec = 0; fnum = op; end
          1: begin vec = 0; fnum = 8 + op; end
          2: begin vec = 1; fnum = op*16; end
          default: begin vec = 1; fnum = op*16 + 8; end
        endcase
      end
      num = (crb != 0) ? fnum*4 + fld%4 : fnum;
    end
    return vec*1000 + num;
  endfunction

  function automatic string req_of(int cr, int crb, int wide, int tag);
    if (cr != 0 && crb != 0) return "R9";
    if (cr != 0) return wide ? "R7" : "R8";
    if (tag == 0) return "R3";
    if (wide == 0) return "R6";
    return (tag >= 4) ? "R5" : "R4";
  endfunction

  task automatic check(string rq, int exp_valid, int exp_code);
    int act;
    act = int'(vec_o)*1000 + int'(regnum_o);
    n_tests++;
    if (int'(valid_o) != exp_valid || act != exp_code) begin
      n_fail++;
      $display("FAIL %s: valid=%0d code=%0d expected valid=%0d code=%0d",
               rq, valid_o, act, exp_valid, exp_code);
    end
  endtask

  task automatic drive(int v, int cr, int crb, int wide, int tag, int fld);
    valid_i = (v != 0);
    cr_i    = (cr != 0);
    crbit_i = (crb != 0);
    wide_i  = (wide != 0);
    tag_i   = 3'(tag);
    field_i = 5'(fld);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: expired, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int last;
    repeat (3) @(negedge clk_i);
    check("R1", 0, 0);                     // in reset
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 0, 0);                     // after release, no valid

    // exhaustive sweep, back-to-back valid
    last = -1;
    for (int cls = 0; cls < 3; cls++)
      for (int w = 0; w < 2; w++)
        for (int t = 0; t < 8; t++)
          for (int f = 0; f < 32; f++) begin
            drive(1, (cls > 0), (cls == 2), w, t, f);
            @(negedge clk_i);
            last = model((cls > 0), (cls == 2), w, t, f);
            check(req_of((cls > 0), (cls == 2), w, t), 1, last);
          end

    // R2: idle cycles with changing inputs hold the last result
    for (int k = 0; k < 6; k++) begin
      drive(0, k % 2, 0, 1, 7 - k, 31 - k);
      @(negedge clk_i);
      check("R2", 0, last);
    end

    // R2: valid again after idle, then idle once more
    drive(1, 0, 0, 1, 5, 9);
    @(negedge clk_i);
    last = 1000 + 9*4 + 1;
    check("R5", 1, last);
    drive(0, 1, 1, 0, 3, 0);
    @(negedge clk_i);
    check("R2", 0, last);

    // R10: upper bits zero for largest int and cr field codes
    drive(1, 0, 0, 1, 3, 31);
    @(negedge clk_i);
    check("R10", 1, 127);
    drive(1, 1, 0, 1, 7, 7);
    @(negedge clk_i);
    check("R10", 1, 1000 + 7*16 + 12);

    // R1: reset in mid-stream clears outputs
    drive(0, 0, 0, 0, 0, 0);
    rst_ni = 1'b0;
    #1;
    check("R1", 0, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule